// File: doc/BRIEF.md
# FP64 Compare-and-Set Unit

This block takes two IEEE-754 double-precision operands and evaluates one of sixteen relational tests between them. Each operand can first be passed through an absolute-value stage and then a negate stage. The second operand comes either from a 64-bit input or from a 20-bit immediate that fills its top bits. The outcome of the test can then be merged with a predicate bit, which may be inverted first, using AND, OR or XOR. The merged truth value becomes a 32-bit word: an all-ones mask, or the single-precision encoding of one. A false value gives zero.

The result word and two condition flags are registered. They update on the clock edge that follows an accepted input and hold their value until the next one. A two-state machine tracks whether the output registers carry a fresh result. **ST_EMPTY** moves to **ST_LOADED** on an edge where `in_valid` is high. **ST_LOADED** stays in place while `in_valid` remains high, and returns to **ST_EMPTY** on an edge where it is low. `out_valid` is high exactly in ST_LOADED.

Top module: `fp64_cmp_set`

## Requirements
- R1: `out_valid` is high in the cycle after an edge with `in_valid` high, and low in the cycle after an edge with `in_valid` low.
- R2: While reset is asserted and after it, before any input is accepted: `out_valid`=0, `result`=0, `flag_zero`=1 and `flag_sign`=0.
- R3: `cond_sel` codes are 0 F, 1 LT, 2 EQ, 3 LE, 4 GT, 5 NE, 6 GE, 7 NUM, 8 NAN, 9 LTU, 10 EQU, 11 LEU, 12 GTU, 13 NEU, 14 GEU, 15 T. F is always false and T is always true, whatever the operands.
- R4: A NaN is an operand whose exponent is all ones and whose fraction is nonzero, whether quiet or signalling. Tests 1–6 are false if either operand is NaN. Tests 9–14 are true if either operand is NaN. NUM is true only when neither operand is NaN. NAN is true when at least one is NaN.
- R5: Non-NaN operands are ordered by value: +0 equals −0, infinities are ordinary extremes, and subnormals compare at their exact value without being flushed to zero.
- R6: For each operand, `*_abs` clears the sign and `*_neg` then flips it, both before the comparison.
- R7: With `imm_sel`=1, operand B is `{imm20, 44'b0}` and `op_b` has no effect.
- R8: With `comb_en`=1, the test result is merged with `pred_in ^ pred_inv`. `comb_op` 0 means AND, 1 means OR, 2 means XOR, and 3 acts as AND. With `comb_en`=0 the test result is used alone.
- R9: A true value gives 0xFFFF_FFFF when `fmt_float`=0 and 0x3F80_0000 when `fmt_float`=1. A false value gives 0.
- R10: `flag_zero` is 1 exactly when `result` is 0. `flag_sign` equals `result[31]`.
- R11: After an edge with `in_valid` low, `result` and both flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept the operands this cycle |
| op_a | input | 64 | Operand A, FP64 bits |
| op_b | input | 64 | Operand B, FP64 bits (register form) |
| imm_sel | input | 1 | Take operand B from the immediate |
| imm20 | input | 20 | Immediate, placed in bits 63:44 of B |
| a_abs | input | 1 | Absolute value on A |
| a_neg | input | 1 | Negate A (after abs) |
| b_abs | input | 1 | Absolute value on B |
| b_neg | input | 1 | Negate B (after abs) |
| cond_sel | input | 4 | Relational test code |
| comb_en | input | 1 | Merge with predicate |
| comb_op | input | 2 | Merge operation |
| pred_in | input | 1 | Predicate bit |
| pred_inv | input | 1 | Invert predicate before merging |
| fmt_float | input | 1 | 1: float-one result, 0: mask result |
| out_valid | output | 1 | Result registers hold a fresh result |
| result | output | 32 | Result word |
| flag_zero | output | 1 | Result is zero |
| flag_sign | output | 1 | Result bit 31 |

## Verification
Some properties are checked by assertions on every cycle. These are the timing of `out_valid` relative to `in_valid`, and that the held outputs stay stable when no input arrives. They also check that a nonzero result is always one of the two legal true words, and that the flags stay consistent with the result word. An F or T test without merging must always give zero or a true word. Only the directed scenarios can show the arithmetic content. That covers the NaN handling of each test family, equality of signed zeros, exact subnormal ordering, the order of the modifier stages, expansion of the immediate, and the merge truth tables with predicate inversion.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [3:0] {
        CND_F   = 4'd0,
        CND_LT  = 4'd1,
        CND_EQ  = 4'd2,
        CND_LE  = 4'd3,
        CND_GT  = 4'd4,
        CND_NE  = 4'd5,
        CND_GE  = 4'd6,
        CND_NUM = 4'd7,
        CND_NAN = 4'd8,
        CND_LTU = 4'd9,
        CND_EQU = 4'd10,
        CND_LEU = 4'd11,
        CND_GTU = 4'd12,
        CND_NEU = 4'd13,
        CND_GEU = 4'd14,
        CND_T   = 4'd15
    } cond_e;

    typedef enum logic [1:0] {
        CMB_AND = 2'd0,
        CMB_OR  = 2'd1,
        CMB_XOR = 2'd2,
        CMB_RSV = 2'd3
    } comb_e;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } state_e;

    // Relation between the two modified operands
    typedef struct packed {
        logic unord;  // at least one NaN
        logic lt;     // a below b (meaningful when ordered)
        logic eq;     // a equal to b (meaningful when ordered)
    } rel_t;

endpackage

// File: rtl/fcs_operand_mod.sv
module fcs_operand_mod #(
    parameter int W = 64
) (
    input  logic [W-1:0] x,
    input  logic         abs_en,
    input  logic         neg_en,
    output logic [W-1:0] y
);
    logic sign_abs;

    // Absolute value first, then negation
    always_comb begin
        sign_abs = abs_en ? 1'b0 : x[W-1];
        y        = {sign_abs ^ neg_en, x[W-2:0]};
    end
endmodule

// File: rtl/fcs_compare_core.sv
module fcs_compare_core
    import fcs_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0] a,
    input  logic [EXP_W+FRAC_W:0] b,
    output rel_t                  rel
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic             a_nan, b_nan;
    logic [W-2:0]     mag_a, mag_b;
    logic             both_zero;
    logic             sa, sb;

    always_comb begin
        sa        = a[W-1];
        sb        = b[W-1];
        mag_a     = a[W-2:0];
        mag_b     = b[W-2:0];
        a_nan     = (&a[W-2:FRAC_W]) && (|a[FRAC_W-1:0]);
        b_nan     = (&b[W-2:FRAC_W]) && (|b[FRAC_W-1:0]);
        both_zero = (mag_a == '0) && (mag_b == '0);

        rel.unord = a_nan | b_nan;
        rel.eq    = both_zero || (a == b);
        if (sa != sb)
            rel.lt = sa && !both_zero;
        else if (sa)
            rel.lt = mag_a > mag_b;
        else
            rel.lt = mag_a < mag_b;
    end
endmodule

// File: rtl/fcs_cond_eval.sv
module fcs_cond_eval
    import fcs_pkg::*;
(
    input  rel_t  rel,
    input  cond_e cond,
    input  logic  comb_en,
    input  comb_e comb_op,
    input  logic  pred_in,
    input  logic  pred_inv,
    output logic  hit
);
    logic gt, ord, test_res, pred_eff;
    comb_e op_eff;

    always_comb begin
        ord = !rel.unord;
        gt  = !rel.lt && !rel.eq;
        unique case (cond)
            CND_F:   test_res = 1'b0;
            CND_LT:  test_res = ord && rel.lt;
            CND_EQ:  test_res = ord && rel.eq;
            CND_LE:  test_res = ord && (rel.lt || rel.eq);
            CND_GT:  test_res = ord && gt;
            CND_NE:  test_res = ord && !rel.eq;
            CND_GE:  test_res = ord && !rel.lt;
            CND_NUM: test_res = ord;
            CND_NAN: test_res = rel.unord;
            CND_LTU: test_res = rel.unord || rel.lt;
            CND_EQU: test_res = rel.unord || rel.eq;
            CND_LEU: test_res = rel.unord || rel.lt || rel.eq;
            CND_GTU: test_res = rel.unord || gt;
            CND_NEU: test_res = rel.unord || !rel.eq;
            CND_GEU: test_res = rel.unord || !rel.lt;
            CND_T:   test_res = 1'b1;
        endcase

        // No merge requested: AND with constant true
        pred_eff = comb_en ? (pred_in ^ pred_inv) : 1'b1;
        op_eff   = comb_en ? comb_op : CMB_AND;

        unique case (op_eff)
            CMB_AND: hit = test_res & pred_eff;
            CMB_OR:  hit = test_res | pred_eff;
            CMB_XOR: hit = test_res ^ pred_eff;
            CMB_RSV: hit = test_res & pred_eff;
        endcase
    end
endmodule

// File: rtl/fp64_cmp_set.sv
module fp64_cmp_set
    import fcs_pkg::*;
#(
    parameter int          EXP_W     = 11,
    parameter int          FRAC_W    = 52,
    parameter int          IMM_W     = 20,
    parameter int          RES_W     = 32,
    parameter logic [31:0] FLOAT_ONE = 32'h3F80_0000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [EXP_W+FRAC_W:0]   op_a,
    input  logic [EXP_W+FRAC_W:0]   op_b,
    input  logic                    imm_sel,
    input  logic [IMM_W-1:0]        imm20,
    input  logic                    a_abs,
    input  logic                    a_neg,
    input  logic                    b_abs,
    input  logic                    b_neg,
    input  logic [3:0]              cond_sel,
    input  logic                    comb_en,
    input  logic [1:0]              comb_op,
    input  logic                    pred_in,
    input  logic                    pred_inv,
    input  logic                    fmt_float,
    output logic                    out_valid,
    output logic [RES_W-1:0]        result,
    output logic                    flag_zero,
    output logic                    flag_sign
);
    localparam int DW = 1 + EXP_W + FRAC_W;

    logic [DW-1:0]    b_src, a_mod, b_mod;
    rel_t             rel;
    logic             hit;
    logic [RES_W-1:0] word_d;
    state_e           state_q, state_d;

    assign b_src = imm_sel ? {imm20, {(DW-IMM_W){1'b0}}} : op_b;

    fcs_operand_mod #(.W(DW)) u_mod_a (.x(op_a),  .abs_en(a_abs), .neg_en(a_neg), .y(a_mod));
    fcs_operand_mod #(.W(DW)) u_mod_b (.x(b_src), .abs_en(b_abs), .neg_en(b_neg), .y(b_mod));

    fcs_compare_core #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_core (
        .a(a_mod), .b(b_mod), .rel(rel)
    );

    fcs_cond_eval u_eval (
        .rel(rel), .cond(cond_e'(cond_sel)), .comb_en(comb_en),
        .comb_op(comb_e'(comb_op)), .pred_in(pred_in), .pred_inv(pred_inv),
        .hit(hit)
    );

    always_comb begin
        if (!hit)
            word_d = '0;
        else if (fmt_float)
            word_d = FLOAT_ONE[RES_W-1:0];
        else
            word_d = '1;
    end

    // Next-state logic
    always_comb begin
        unique case (state_q)
            ST_EMPTY:  state_d = in_valid ? ST_LOADED : ST_EMPTY;
            ST_LOADED: state_d = in_valid ? ST_LOADED : ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            flag_zero <= 1'b1;
            flag_sign <= 1'b0;
        end else if (in_valid) begin
            result    <= word_d;
            flag_zero <= (word_d == '0);
            flag_sign <= word_d[RES_W-1];
        end
    end

    assign out_valid = (state_q == ST_LOADED);

    assert_valid_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_const_false_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !comb_en && cond_sel == 4'd0) |=> (result == '0));
    assert_const_true_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !comb_en && cond_sel == 4'd15) |=> (result != '0));
    assert_legal_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (result != '0) |-> (result == '1 || result == FLOAT_ONE[RES_W-1:0]));
    assert_flags_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_zero == (result == '0)) && (flag_sign == result[RES_W-1]));
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(flag_zero) && $stable(flag_sign)));
endmodule

// File: tb/test_fp64_cmp_set.sv
module test_fp64_cmp_set;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] op_a, op_b;
    logic        imm_sel;
    logic [19:0] imm20;
    logic        a_abs, a_neg, b_abs, b_neg;
    logic [3:0]  cond_sel;
    logic        comb_en;
    logic [1:0]  comb_op;
    logic        pred_in, pred_inv, fmt_float;
    logic        out_valid;
    logic [31:0] result;
    logic        flag_zero, flag_sign;

    int errors = 0;
    int checks = 0;

    localparam logic [63:0] ONE    = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] TWO    = 64'h4000_0000_0000_0000;
    localparam logic [63:0] HALF   = 64'h3FE0_0000_0000_0000;
    localparam logic [63:0] M_ONE  = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] M_TWO  = 64'hC000_0000_0000_0000;
    localparam logic [63:0] P_ZERO = 64'h0;
    localparam logic [63:0] N_ZERO = 64'h8000_0000_0000_0000;
    localparam logic [63:0] QNAN   = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] SNAN   = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] INF    = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] SUB1   = 64'h0000_0000_0000_0001;
    localparam logic [63:0] SUB2   = 64'h0000_0000_0000_0002;

    always #5 clk = ~clk;

    fp64_cmp_set i_fp64_cmp_set (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .imm_sel(imm_sel), .imm20(imm20), .a_abs(a_abs), .a_neg(a_neg),
        .b_abs(b_abs), .b_neg(b_neg), .cond_sel(cond_sel), .comb_en(comb_en),
        .comb_op(comb_op), .pred_in(pred_in), .pred_inv(pred_inv),
        .fmt_float(fmt_float), .out_valid(out_valid), .result(result),
        .flag_zero(flag_zero), .flag_sign(flag_sign)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic clear_in();
        in_valid = 0; op_a = '0; op_b = '0; imm_sel = 0; imm20 = '0;
        a_abs = 0; a_neg = 0; b_abs = 0; b_neg = 0; cond_sel = 4'd0;
        comb_en = 0; comb_op = 2'd0; pred_in = 0; pred_inv = 0; fmt_float = 0;
    endtask

    // Apply one operation at a negedge and check the result after the next posedge
    task automatic run(input string req, input logic [63:0] a, input logic [63:0] b,
                       input logic [3:0] cnd, input logic exp_true);
        logic [31:0] expw;
        @(negedge clk);
        op_a = a; op_b = b; cond_sel = cnd; in_valid = 1;
        @(posedge clk); #1;
        expw = exp_true ? (fmt_float ? 32'h3F80_0000 : 32'hFFFF_FFFF) : 32'h0;
        chk(req, result, expw);
        chk({req, " valid R1"}, {31'b0, out_valid}, 32'd1);
        chk({req, " zero flag R10"}, {31'b0, flag_zero}, {31'b0, expw == 32'h0});
        chk({req, " sign flag R10"}, {31'b0, flag_sign}, {31'b0, expw[31]});
        in_valid = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; clear_in();
        repeat (3) @(posedge clk);
        #1;
        chk("R2 out_valid", {31'b0, out_valid}, 32'd0);
        chk("R2 result", result, 32'd0);
        chk("R2 flag_zero", {31'b0, flag_zero}, 32'd1);
        chk("R2 flag_sign", {31'b0, flag_sign}, 32'd0);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
        chk("R2 after release", {31'b0, out_valid}, 32'd0);
    endtask

    task automatic t_const();
        run("R3 F", ONE, TWO, 4'd0, 1'b0);
        run("R3 F nan", QNAN, QNAN, 4'd0, 1'b0);
        run("R3 T nan", QNAN, SNAN, 4'd15, 1'b1);
    endtask

    task automatic t_nan();
        run("R4 LT nan", QNAN, ONE, 4'd1, 1'b0);
        run("R4 EQ nan", SNAN, SNAN, 4'd2, 1'b0);
        run("R4 NE nan", ONE, QNAN, 4'd5, 1'b0);
        run("R4 LTU nan", QNAN, ONE, 4'd9, 1'b1);
        run("R4 GEU nan", ONE, SNAN, 4'd14, 1'b1);
        run("R4 LTU ordered", TWO, ONE, 4'd9, 1'b0);
        run("R4 NUM", ONE, TWO, 4'd7, 1'b1);
        run("R4 NUM nan", ONE, SNAN, 4'd7, 1'b0);
        run("R4 NAN snan", ONE, SNAN, 4'd8, 1'b1);
        run("R4 NAN inf", INF, INF, 4'd8, 1'b0);
        run("R4 EQ inf", INF, INF, 4'd2, 1'b1);
    endtask

    task automatic t_order();
        run("R5 LT pos", ONE, TWO, 4'd1, 1'b1);
        run("R5 GT neg", M_ONE, M_TWO, 4'd4, 1'b1);
        run("R5 LT neg", M_ONE, M_TWO, 4'd1, 1'b0);
        run("R5 LT mixed", M_ONE, P_ZERO, 4'd1, 1'b1);
        run("R5 EQ zeros", P_ZERO, N_ZERO, 4'd2, 1'b1);
        run("R5 NE zeros", N_ZERO, P_ZERO, 4'd5, 1'b0);
        run("R5 LT zeros", N_ZERO, P_ZERO, 4'd1, 1'b0);
        run("R5 LT subnormal", SUB1, SUB2, 4'd1, 1'b1);
        run("R5 GT subnormal zero", SUB1, P_ZERO, 4'd4, 1'b1);
        run("R5 LE", TWO, TWO, 4'd3, 1'b1);
        run("R5 GE", ONE, TWO, 4'd6, 1'b0);
        run("R5 GTU", TWO, INF, 4'd12, 1'b0);
    endtask

    task automatic t_mods();
        a_abs = 1;
        run("R6 abs", M_ONE, ONE, 4'd2, 1'b1);
        a_neg = 1;
        run("R6 abs then neg", ONE, HALF, 4'd1, 1'b1);
        a_abs = 0; a_neg = 0; b_neg = 1;
        run("R6 neg b", ONE, TWO, 4'd1, 1'b0);
        b_abs = 1;
        run("R6 abs neg b", M_ONE, TWO, 4'd4, 1'b1);
        b_abs = 0; b_neg = 0;
    endtask

    task automatic t_imm();
        imm_sel = 1; imm20 = 20'h3FF00;
        run("R7 imm eq", ONE, QNAN, 4'd2, 1'b1);
        imm20 = 20'h40000;
        run("R7 imm lt", ONE, M_TWO, 4'd1, 1'b1);
        imm_sel = 0;
    endtask

    task automatic t_comb();
        comb_en = 1;
        comb_op = 2'd0; pred_in = 0;
        run("R8 AND p0", ONE, ONE, 4'd2, 1'b0);
        pred_inv = 1;
        run("R8 AND inv", ONE, ONE, 4'd2, 1'b1);
        pred_inv = 0; comb_op = 2'd1; pred_in = 1;
        run("R8 OR", ONE, TWO, 4'd2, 1'b1);
        comb_op = 2'd2;
        run("R8 XOR", ONE, ONE, 4'd2, 1'b0);
        pred_in = 0;
        run("R8 XOR p0", ONE, ONE, 4'd2, 1'b1);
        comb_op = 2'd3;
        run("R8 rsv as AND", ONE, ONE, 4'd2, 1'b0);
        comb_en = 0;
        run("R8 no merge", ONE, ONE, 4'd2, 1'b1);
        comb_op = 2'd0;
    endtask

    task automatic t_fmt();
        fmt_float = 1;
        run("R9 float", ONE, TWO, 4'd1, 1'b1);
        run("R9 float false", TWO, ONE, 4'd1, 1'b0);
        fmt_float = 0;
        run("R9 mask", ONE, TWO, 4'd1, 1'b1);
    endtask

    task automatic t_hold();
        run("R11 load", ONE, TWO, 4'd1, 1'b1);
        @(negedge clk);
        in_valid = 0; op_a = TWO; op_b = ONE; fmt_float = 1;
        repeat (2) @(posedge clk);
        #1;
        chk("R11 hold result", result, 32'hFFFF_FFFF);
        chk("R11 hold zero", {31'b0, flag_zero}, 32'd0);
        chk("R1 idle valid", {31'b0, out_valid}, 32'd0);
        fmt_float = 0;
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_const();
                t_nan();
                t_order();
                t_mods();
                t_imm();
                t_comb();
                t_fmt();
                t_hold();
            end
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule